// File: doc/BRIEF.md
# Saturating Clear-on-Read Cell Drop Counter

This block keeps a running total of receive cells that the cell path throws away. Each discard cause drives its own single-cycle strobe. The causes are an uncorrectable header-check error, a user filter drop (idle cells included), and a failed write into the receive FIFO. In every clock cycle the block adds the number of strobes that are high. The total stops at full scale and does not wrap.

Software reads the total through a byte-wide read port. The total is wider than the port, so it is read as several byte registers. Reading the most significant byte takes a snapshot of the whole live count and clears the live counter in the same cycle. The lower bytes are then read from that snapshot, so all bytes belong to the same instant even while new events arrive. A discard that lands in the same cycle as the clearing read is not lost. It becomes the first count of the new interval.

Top module: `cell_drop_counter`

## Requirements
- R1: After a synchronous active-high reset, `rd_data` is zero, and both the live count and the snapshot read back as zero.
- R2: A strobe on any one discard input (bit 0 header-check error, bit 1 user filter drop, bit 2 FIFO write error) adds exactly one to the live count.
- R3: When several discard strobes are high in the same cycle, the live count grows by the number of high strobes.
- R4: The live count stops at all-ones (0xFFFFFFFF at the default 32-bit width) and stays there under further events; it never wraps to zero.
- R5: A read of the top byte address (3 at default width) returns the most significant byte of the live count, copies the whole live count into the snapshot, and clears the live count in that same cycle.
- R6: A read of byte address k below the top returns bits [8k+7:8k] of the snapshot; address 0 holds the least significant byte.
- R7: Reads of the lower byte addresses do not change the live count or the snapshot.
- R8: Discard strobes that are high in the cycle of a clearing top-byte read are counted in the new interval: the live count restarts at the number of those strobes.
- R9: `rd_data` is updated in the clock cycle after a read is issued, and it holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drop_evt | input | NUM_SRC (3) | One discard strobe per cause: bit 0 header-check error, bit 1 user filter drop, bit 2 FIFO write error |
| rd_en | input | 1 | Read strobe, one cycle per byte read |
| rd_addr | input | ADDR_W (2) | Byte address; the top address reads the MSB and clears the count |
| rd_data | output | BYTE_W (8) | Registered read data, valid the cycle after `rd_en` |

## Verification
The assertions check the following on every cycle:
- The count never drops outside a clearing read.
- A count at full scale holds there.
- A clearing read reloads the count with exactly the strobes of that cycle.
- The snapshot changes only on a top-byte read.
- The read data holds while no read is issued.

The bench scenarios check what needs a reference total over many cycles:
- the byte order of a split read;
- that a lower-byte read leaves the count running;
- that a coinciding event lands in the next interval;
- that a narrow instance really stops at all-ones after tens of thousands of events.

// File: rtl/cell_drop_pkg.sv
package cell_drop_pkg;

   // Kind of access seen on the read port in one cycle
   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_SNAP = 2'd1,
      RD_HELD = 2'd2
   } rd_kind_e;

   function automatic int addr_bits(input int n_bytes);
      return (n_bytes > 1) ? $clog2(n_bytes) : 1;
   endfunction

endpackage

// File: rtl/drop_evt_merge.sv
module drop_evt_merge #(
   parameter int NUM_SRC = 3,
   parameter int INC_W   = 2
) (
   input  logic [NUM_SRC-1:0] evt,
   output logic [INC_W-1:0]   inc
);

   logic [INC_W-1:0] part [NUM_SRC+1];

   assign part[0] = '0;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign part[g+1] = part[g] + INC_W'(evt[g]);
   end

   assign inc = part[NUM_SRC];

   always_comb begin
      AST_INC_BOUND: assert (int'(inc) <= NUM_SRC); // R3
   end

endmodule

// File: rtl/sat_accum.sv
module sat_accum #(
   parameter int CNT_W = 32,
   parameter int INC_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] cnt
);

   localparam int SUM_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] FULL = '1;

   logic [SUM_W-1:0] base;
   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      base = clr ? '0 : {1'b0, cnt};
      sum  = base + SUM_W'(inc);
      nxt  = sum[CNT_W] ? FULL : sum[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= nxt;
   end

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cnt == FULL && !clr) |=> cnt == FULL); // R4

   AST_NO_DROP: assert property (@(posedge clk) disable iff (rst)
      !clr |=> cnt >= $past(cnt)); // R4

   AST_RESTART: assert property (@(posedge clk) disable iff (rst)
      clr |=> cnt == CNT_W'($past(inc))); // R8

endmodule

// File: rtl/snap_reader.sv
module snap_reader
   import cell_drop_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 4,
   parameter int ADDR_W    = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CNT_W-1:0]  live,
   output logic              clr,
   output logic [BYTE_W-1:0] rd_data
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_BYTES - 1);

   logic [CNT_W-1:0]  snap;
   logic [BYTE_W-1:0] snap_lane [NUM_BYTES];
   logic [BYTE_W-1:0] held_pick;
   rd_kind_e          kind;

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
      assign snap_lane[g] = snap[g*BYTE_W +: BYTE_W];
   end

   always_comb begin
      if (!rd_en)                   kind = RD_IDLE;
      else if (rd_addr == TOP_ADDR) kind = RD_SNAP;
      else                          kind = RD_HELD;
   end

   assign clr = (kind == RD_SNAP);

   always_comb begin
      held_pick = '0;
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (rd_addr == ADDR_W'(i)) held_pick = snap_lane[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         snap    <= '0;
         rd_data <= '0;
      end else begin
         case (kind)
            RD_SNAP: begin
               snap    <= live;
               rd_data <= live[CNT_W-1 -: BYTE_W];
            end
            RD_HELD: rd_data <= held_pick;
            default: ;
         endcase
      end
   end

   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_addr == TOP_ADDR) |=> snap == $past(live)); // R5

   AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (rst)
      !(rd_en && rd_addr == TOP_ADDR) |=> $stable(snap)); // R7

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data)); // R9

endmodule

// File: rtl/cell_drop_counter.sv
module cell_drop_counter
   import cell_drop_pkg::*;
#(
   parameter  int CNT_W   = 32,
   parameter  int BYTE_W  = 8,
   parameter  int NUM_SRC = 3,
   localparam int NUM_BYTES = CNT_W / BYTE_W,
   localparam int ADDR_W    = addr_bits(NUM_BYTES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] drop_evt,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [BYTE_W-1:0]  rd_data
);

   localparam int INC_W = $clog2(NUM_SRC + 1);

   if (CNT_W % BYTE_W != 0) begin : g_bad_width
      $error("CNT_W must be a whole number of BYTE_W lanes");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("NUM_SRC must be at least one");
   end
   if (INC_W >= CNT_W) begin : g_bad_inc
      $error("CNT_W too narrow for NUM_SRC");
   end

   logic [INC_W-1:0] inc;
   logic [CNT_W-1:0] live;
   logic             clr;

   drop_evt_merge #(
      .NUM_SRC (NUM_SRC),
      .INC_W   (INC_W)
   ) i_merge (
      .evt (drop_evt),
      .inc (inc)
   );

   sat_accum #(
      .CNT_W (CNT_W),
      .INC_W (INC_W)
   ) i_accum (
      .clk (clk),
      .rst (rst),
      .clr (clr),
      .inc (inc),
      .cnt (live)
   );

   snap_reader #(
      .CNT_W     (CNT_W),
      .BYTE_W    (BYTE_W),
      .NUM_BYTES (NUM_BYTES),
      .ADDR_W    (ADDR_W)
   ) i_reader (
      .clk     (clk),
      .rst     (rst),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .live    (live),
      .clr     (clr),
      .rd_data (rd_data)
   );

   AST_CLR_ONLY_TOP: assert property (@(posedge clk) disable iff (rst)
      clr |-> (rd_en && rd_addr == ADDR_W'(NUM_BYTES - 1))); // R5

endmodule

// File: tb/test_cell_drop_counter.sv
module test_cell_drop_counter;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] evt = '0;
   logic       rd_en = 1'b0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;

   logic [2:0] s_evt = '0;
   logic       s_rd = 1'b0;
   logic       s_addr = 1'b0;
   logic [7:0] s_data;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_live = '0;
   logic [31:0] m_snap = '0;
   logic [7:0]  qv [$];
   string       qt [$];

   always #4 clk = ~clk;

   cell_drop_counter i_cell_drop_counter (
      .clk (clk), .rst (rst), .drop_evt (evt),
      .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data)
   );

   cell_drop_counter #(.CNT_W(16)) i_cell_drop_counter_sat (
      .clk (clk), .rst (rst), .drop_evt (s_evt),
      .rd_en (s_rd), .rd_addr (s_addr), .rd_data (s_data)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: one cycle of stimulus, updates the reference model
   task automatic cyc(input logic [2:0] ev, input logic rd, input logic [1:0] a, input string tag);
      int n;
      @(negedge clk);
      evt = ev; rd_en = rd; rd_addr = a;
      n = $countones(ev);
      if (rd) begin
         if (a == 2'd3) begin
            qv.push_back(m_live[31:24]);
            m_snap = m_live;
            m_live = 32'(n);
         end else begin
            qv.push_back(m_snap[a*8 +: 8]);
            m_live = m_live + 32'(n);
         end
         qt.push_back(tag);
      end else begin
         m_live = m_live + 32'(n);
      end
   endtask

   task automatic burst(input logic [2:0] ev, input int cnt);
      for (int i = 0; i < cnt; i++) cyc(ev, 1'b0, 2'd0, "");
   endtask

   // Monitor: compares each read result one cycle after it was issued
   initial begin
      logic p;
      forever begin
         @(posedge clk);
         p = rd_en && !rst;
         @(negedge clk);
         if (p) begin
            if (qv.size() == 0) begin
               checks++; errors++;
               $display("FAIL scoreboard: got %h expected nothing", rd_data);
            end else begin
               check(rd_data, qv.pop_front(), qt.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(rd_data, 8'h00, "R1 reset data");
      cyc(3'b000, 1'b1, 2'd3, "R1 reset msb");
      cyc(3'b000, 1'b1, 2'd0, "R1 reset lsb");

      // R2: single sources
      burst(3'b001, 5);
      burst(3'b010, 2);
      burst(3'b100, 1);
      cyc(3'b000, 1'b1, 2'd3, "R2 msb");
      cyc(3'b000, 1'b1, 2'd0, "R2 single strobes lsb");

      // R3 and R6: simultaneous strobes, byte order
      burst(3'b111, 100);
      burst(3'b011, 50);
      cyc(3'b000, 1'b1, 2'd3, "R3 msb");
      cyc(3'b000, 1'b1, 2'd1, "R6 byte1");
      cyc(3'b000, 1'b1, 2'd0, "R6 byte0");
      cyc(3'b000, 1'b1, 2'd2, "R6 byte2");

      // R7: lower reads leave live count running
      burst(3'b001, 10);
      cyc(3'b000, 1'b1, 2'd0, "R7 old snapshot");
      burst(3'b100, 5);
      cyc(3'b000, 1'b1, 2'd1, "R7 old snapshot hi");
      cyc(3'b000, 1'b1, 2'd3, "R7 msb");
      cyc(3'b000, 1'b1, 2'd0, "R7 full count");

      // R8: event coincident with clearing read
      burst(3'b010, 4);
      cyc(3'b111, 1'b1, 2'd3, "R8 msb");
      cyc(3'b000, 1'b1, 2'd0, "R8 before clear");
      cyc(3'b000, 1'b1, 2'd3, "R8 msb2");
      cyc(3'b000, 1'b1, 2'd0, "R8 restart count");

      // R5: clear leaves zero
      cyc(3'b000, 1'b1, 2'd3, "R5 msb after clear");
      cyc(3'b000, 1'b1, 2'd0, "R5 cleared");

      // R9: data holds with no read
      cyc(3'b011, 1'b0, 2'd1, "");
      cyc(3'b000, 1'b0, 2'd0, "");
      cyc(3'b000, 1'b0, 2'd0, "");
      check(rd_data, m_snap[7:0], "R9 hold");

      // R4: saturation on a 16-bit instance
      @(negedge clk);
      s_evt = 3'b111;
      repeat (22000) @(negedge clk);
      s_evt = 3'b000;
      s_rd = 1'b1; s_addr = 1'b1;
      @(negedge clk);
      s_rd = 1'b1; s_addr = 1'b0;
      check(s_data, 8'hFF, "R4 sat msb");
      @(negedge clk);
      s_rd = 1'b1; s_addr = 1'b1;
      check(s_data, 8'hFF, "R4 sat lsb");
      @(negedge clk);
      s_rd = 1'b0;
      check(s_data, 8'h00, "R4 cleared after sat");

      repeat (3) @(negedge clk);
      if (qv.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: got %0d pending expected 0", qv.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule